// File: doc/BRIEF.md
# Multi-Lane Deskew Release Controller

This block sits after the per-lane decoders of a multi-lane receive link. Each lane buffers its data from the moment its own alignment-start marker appears. The lanes arrive at different times because of skew. Once every active lane has arrived, all lane buffers begin to drain in the same cycle, so the words at the output are aligned across lanes. The release happens at a programmable distance before the local multiframe boundary.

The block also reports two things. It records where the latest lane landed relative to the boundary, so firmware can pick a safe release offset. It raises a sticky error when the lanes are spread over more than one multiframe boundary.

Lanes can be masked off. The start marker can come either from the alignment sequence or from the direct entry into user data when lane synchronization is skipped. A link reinitialization pulse re-arms the whole process.

Top module: `lane_deskew_release`

## Requirements
- R1: After reset, `out_valid`, `deskew_err` and `arr_count` are all 0.
- R2: Once released, every active lane outputs its buffered words in order, one per cycle, and all lanes step together.
  - The first valid word of a lane is the word that was present on `lane_din` in that lane's marker cycle.
  - `out_valid` first rises two cycles after the release cycle and then stays high until reinitialization.
- R3: The distance to the boundary is `pos = mf_last - mf_count`. The tick cycle, where `mf_count == mf_last`, has `pos` 0.
  - Release occurs in the first cycle, at or after the latest arrival, in which `pos == rel_offset`.
- R4: When `rel_offset > mf_last`, release occurs in the cycle in which the latest lane arrives.
- R5: When `force_rel` is 1, release occurs in the cycle in which the latest lane arrives, whatever `rel_offset` holds.
- R6: `arr_count` holds `pos` of the cycle in which the last active lane arrived. It is 0 for an arrival in the tick cycle and 1 for an arrival one cycle earlier.
- R7: `deskew_err` goes to 1 and stays there when a second tick cycle ends while at least one active lane has arrived and another has not.
  - A lane arriving in a tick cycle counts as arriving before that boundary.
  - A single boundary crossed is legal.
- R8: A lane whose `lane_off` bit is 1 is ignored by arrival tracking and the skew check, and its output word reads 0.
- R9: With `sync_en` = 1 the lane marker is `ilas_mark`, and with `sync_en` = 0 it is `user_mark`. The other marker input has no effect.
- R10: Release happens once per initialization, and further markers on an already-arrived lane are ignored.
  - A `relink` pulse clears `out_valid`, `deskew_err`, `arr_count` and all arrivals by the next cycle, and re-arms the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst | input | 1 | Synchronous active-high reset |
| relink | input | 1 | Link reinitialization pulse, re-arms the block |
| sync_en | input | 1 | 1: marker from alignment sequence, 0: marker from user-data entry |
| force_rel | input | 1 | Release as soon as the latest lane arrives |
| rel_offset | input | CW | Release distance before the boundary, in link clocks |
| lane_off | input | LANES | Per-lane power-down mask |
| ilas_mark | input | LANES | Per-lane alignment-sequence start pulse |
| user_mark | input | LANES | Per-lane direct user-data start pulse |
| lane_din | input | LANES*DW | Per-lane received words |
| mf_count | input | CW | Position inside the local multiframe |
| mf_last | input | CW | Last multiframe position, (F*K/4)-1 |
| mf_tick | input | 1 | High in the last cycle of each multiframe |
| lane_dout | output | LANES*DW | Aligned per-lane words |
| out_valid | output | 1 | Aligned words are valid |
| arr_count | output | CW | Measured arrival position of the latest lane |
| deskew_err | output | 1 | Lanes spread across more than one boundary |

## Verification
The bench targets the arrival that lands exactly on a tick. A design that counts the boundary one cycle off would report an arrival count of 7 instead of 0 and would release a full multiframe late. It also programs an offset equal to the arrival position, where a design that needs one extra cycle of "all arrived" would wait a whole multiframe. An out-of-range offset checks that the design does not hang waiting for a position that never comes. Skew is exercised on both sides of the limit, with one boundary crossed and with two, so a design that counts the first crossing as an error, or never flags one, is caught. Masked lanes, decoy markers on the unselected source, and a repeated marker before release are each expected to leave the output stream untouched.

// File: rtl/lane_deskew_pkg.sv
package lane_deskew_pkg;

    localparam int CW = 8;

    typedef logic [CW-1:0] mf_pos_t;

    typedef enum logic {
        REL_WAIT = 1'b0,
        REL_RUN  = 1'b1
    } rel_state_e;

    // link clocks remaining until the multiframe boundary
    function automatic mf_pos_t to_boundary(input mf_pos_t last, input mf_pos_t cnt);
        return last - cnt;
    endfunction

endpackage

// File: rtl/lane_deskew_buf.sv
module lane_deskew_buf #(
    parameter int DW    = 32,
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          relink,
    input  logic          mark,
    input  logic          en,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);
    logic          armed;
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] wr_addr;
    logic          wr_go;
    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] q;

    assign wr_go   = en & (armed | mark);
    assign wr_addr = armed ? wr_ptr : '0;

    always_ff @(posedge clk) begin
        if (rst || relink) begin
            armed  <= 1'b0;
            wr_ptr <= '0;
        end else if (wr_go) begin
            armed  <= 1'b1;
            wr_ptr <= wr_addr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_go) mem[wr_addr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst)        q <= '0;
        else if (rd_en) q <= mem[rd_addr];
    end

    assign dout = en ? q : '0;
endmodule

// File: rtl/lane_deskew_track.sv
module lane_deskew_track
    import lane_deskew_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             relink,
    input  logic [LANES-1:0] mark,
    input  logic [LANES-1:0] active,
    input  logic             mf_tick,
    input  mf_pos_t          pos,
    output logic             all_now,
    output mf_pos_t          arr_count,
    output logic             deskew_err
);
    logic [LANES-1:0] arrived_q;
    logic [LANES-1:0] arr_now;
    logic             any_now;
    logic             done_q;
    logic             crossed_q;

    assign arr_now = (arrived_q | mark) & active;
    assign any_now = |arr_now;
    assign all_now = (&(arr_now | ~active)) & (|active);

    always_ff @(posedge clk) begin
        if (rst || relink) begin
            arrived_q  <= '0;
            done_q     <= 1'b0;
            crossed_q  <= 1'b0;
            arr_count  <= '0;
            deskew_err <= 1'b0;
        end else begin
            arrived_q <= arr_now;
            if (all_now && !done_q) begin
                done_q    <= 1'b1;
                arr_count <= pos;
            end
            if (mf_tick && any_now && !all_now && !done_q) begin
                crossed_q <= 1'b1;
                if (crossed_q) deskew_err <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/lane_deskew_rel.sv
module lane_deskew_rel
    import lane_deskew_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          relink,
    input  logic          all_now,
    input  mf_pos_t       pos,
    input  mf_pos_t       rel_offset,
    input  mf_pos_t       mf_last,
    input  logic          force_rel,
    output logic          rd_en,
    output logic [AW-1:0] rd_addr,
    output logic          out_valid
);
    rel_state_e state;
    logic       go;

    assign go    = (state == REL_WAIT) && all_now &&
                   (force_rel || (rel_offset > mf_last) || (pos == rel_offset));
    assign rd_en = (state == REL_RUN);

    always_ff @(posedge clk) begin
        if (rst || relink) begin
            state     <= REL_WAIT;
            rd_addr   <= '0;
            out_valid <= 1'b0;
        end else begin
            if (go) state <= REL_RUN;
            if (rd_en) rd_addr <= rd_addr + 1'b1;
            out_valid <= rd_en;
        end
    end
endmodule

// File: rtl/lane_deskew_release.sv
module lane_deskew_release
    import lane_deskew_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int DW     = 32,
    parameter int MF_MAX = 16,
    localparam int DEPTH = 4 * MF_MAX,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      relink,
    input  logic                      sync_en,
    input  logic                      force_rel,
    input  logic [CW-1:0]             rel_offset,
    input  logic [LANES-1:0]          lane_off,
    input  logic [LANES-1:0]          ilas_mark,
    input  logic [LANES-1:0]          user_mark,
    input  logic [LANES-1:0][DW-1:0]  lane_din,
    input  logic [CW-1:0]             mf_count,
    input  logic [CW-1:0]             mf_last,
    input  logic                      mf_tick,
    output logic [LANES-1:0][DW-1:0]  lane_dout,
    output logic                      out_valid,
    output logic [CW-1:0]             arr_count,
    output logic                      deskew_err
);
    logic [LANES-1:0] mark;
    logic [LANES-1:0] active;
    logic             all_now;
    logic             rd_en;
    logic [AW-1:0]    rd_addr;
    mf_pos_t          pos;

    assign mark   = sync_en ? ilas_mark : user_mark;
    assign active = ~lane_off;
    assign pos    = to_boundary(mf_last, mf_count);

    lane_deskew_track #(.LANES(LANES)) u_track (
        .clk(clk), .rst(rst), .relink(relink), .mark(mark), .active(active),
        .mf_tick(mf_tick), .pos(pos), .all_now(all_now),
        .arr_count(arr_count), .deskew_err(deskew_err)
    );

    lane_deskew_rel #(.AW(AW)) u_rel (
        .clk(clk), .rst(rst), .relink(relink), .all_now(all_now), .pos(pos),
        .rel_offset(rel_offset), .mf_last(mf_last), .force_rel(force_rel),
        .rd_en(rd_en), .rd_addr(rd_addr), .out_valid(out_valid)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        lane_deskew_buf #(.DW(DW), .DEPTH(DEPTH)) u_buf (
            .clk(clk), .rst(rst), .relink(relink), .mark(mark[g]), .en(active[g]),
            .rd_en(rd_en), .rd_addr(rd_addr), .din(lane_din[g]), .dout(lane_dout[g])
        );
    end
endmodule

// File: rtl/lane_deskew_release_chk.sv
module lane_deskew_release_chk #(
    parameter int CW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          relink,
    input logic          out_valid,
    input logic [CW-1:0] arr_count,
    input logic          deskew_err
);
    // R2
    valid_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !relink) |=> out_valid);

    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (deskew_err && !relink) |=> deskew_err);

    // R6
    arr_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !relink) |=> $stable(arr_count));

    // R10
    relink_clear_chk: assert property (@(posedge clk) disable iff (rst)
        relink |=> (!out_valid && !deskew_err && arr_count == '0));
endmodule

bind lane_deskew_release lane_deskew_release_chk #(.CW(lane_deskew_pkg::CW)) u_chk (
    .clk(clk), .rst(rst), .relink(relink), .out_valid(out_valid),
    .arr_count(arr_count), .deskew_err(deskew_err)
);

// File: tb/lane_deskew_release_test.sv
module lane_deskew_release_test;
    localparam int L  = 4;
    localparam int DW = 32;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               relink = 1'b0;
    logic               sync_en = 1'b1;
    logic               force_rel = 1'b0;
    logic [7:0]         rel_offset = '0;
    logic [L-1:0]       lane_off = '0;
    logic [L-1:0]       ilas_mark = '0;
    logic [L-1:0]       user_mark = '0;
    logic [L-1:0][DW-1:0] lane_din = '0;
    logic [7:0]         mf_count = '0;
    logic [7:0]         mf_last = 8'd7;
    logic               mf_tick = 1'b0;
    logic [L-1:0][DW-1:0] lane_dout;
    logic               out_valid;
    logic [7:0]         arr_count;
    logic               deskew_err;

    lane_deskew_release #(.LANES(L), .DW(DW), .MF_MAX(16)) uut (
        .clk(clk), .rst(rst), .relink(relink), .sync_en(sync_en), .force_rel(force_rel),
        .rel_offset(rel_offset), .lane_off(lane_off), .ilas_mark(ilas_mark),
        .user_mark(user_mark), .lane_din(lane_din), .mf_count(mf_count),
        .mf_last(mf_last), .mf_tick(mf_tick), .lane_dout(lane_dout),
        .out_valid(out_valid), .arr_count(arr_count), .deskew_err(deskew_err)
    );

    always #5 clk = ~clk;

    typedef struct {
        int       t;
        int       arr;
        int       err;
        int       mk[L];
        logic [L-1:0] pd;
        string    tag;
    } exp_t;

    exp_t sb[$];
    exp_t cur;
    int   checks = 0;
    int   errors = 0;
    int   tcnt = 0;
    int   relink_at = -100;
    int   mk_i[L] = '{-1, -1, -1, -1};
    int   mk_u[L] = '{-1, -1, -1, -1};
    int   mk_x[L] = '{-1, -1, -1, -1};
    int   beat = 0;
    bit   prev_v = 1'b0;

    task automatic check(input bit ok, input string req, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, expv, tcnt);
        end
    endtask

    // monitor then driver, both on the falling edge
    always @(negedge clk) begin
        if (!rst) begin
            if (tcnt == relink_at)
                check(!out_valid && !deskew_err, "R10 relink clears", {out_valid, deskew_err}, 0);
            if (out_valid && !prev_v) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R2 unexpected release", tcnt, -1);
                end else begin
                    cur = sb.pop_front();
                    check(tcnt == cur.t + 1, {cur.tag, " release cycle"}, tcnt, cur.t + 1);
                    check(int'(arr_count) == cur.arr, "R6 arrival count", arr_count, cur.arr);
                    check(int'(deskew_err) == cur.err, "R7 deskew error", deskew_err, cur.err);
                end
                beat = 0;
            end
            if (out_valid && beat < 3) begin
                for (int k = 0; k < L; k++) begin
                    logic [DW-1:0] ev;
                    ev = cur.pd[k] ? '0 : {8'(k), 24'(cur.mk[k] + beat)};
                    check(lane_dout[k] == ev, cur.pd[k] ? "R8 masked lane" : "R2 lane stream",
                          lane_dout[k], ev);
                end
                beat++;
            end
        end
        prev_v = out_valid;
        tcnt++;
        mf_count = 8'(tcnt % 8);
        mf_tick  = (tcnt % 8) == 7;
        relink   = (tcnt == relink_at);
        for (int k = 0; k < L; k++) begin
            lane_din[k]  = {8'(k), 24'(tcnt)};
            ilas_mark[k] = (tcnt == mk_i[k]) || (tcnt == mk_x[k]);
            user_mark[k] = (tcnt == mk_u[k]);
        end
    end

    task automatic run_case(input int d0, input int d1, input int d2, input int d3,
                            input int off, input bit frc, input logic [L-1:0] pd,
                            input bit sync, input int x0, input string tag);
        int   d[L];
        int   base;
        int   a;
        int   first;
        int   cnt;
        exp_t e;
        d = '{d0, d1, d2, d3};
        @(posedge clk);
        base = ((tcnt / 8) + 2) * 8;
        relink_at = base - 4;
        @(negedge clk);
        rel_offset = 8'(off);
        force_rel  = frc;
        lane_off   = pd;
        sync_en    = sync;
        a = -1;
        first = 1 << 30;
        for (int k = 0; k < L; k++) begin
            int m;
            m = (d[k] < 0) ? -1 : base + d[k];
            e.mk[k] = m;
            if (sync) begin
                mk_i[k] = m;
                mk_u[k] = (m < 0) ? -1 : m - 3;
            end else begin
                mk_u[k] = m;
                mk_i[k] = (m < 0) ? -1 : m - 3;
            end
            mk_x[k] = -1;
            if (!pd[k] && m >= 0) begin
                if (m > a) a = m;
                if (m < first) first = m;
            end
        end
        mk_x[0] = (x0 < 0) ? -1 : base + x0;
        e.t = a;
        if (!frc && off <= 7)
            while ((7 - (e.t % 8)) != off) e.t++;
        cnt = 0;
        for (int c = first; c < a; c++)
            if (c % 8 == 7) cnt++;
        e.err = (cnt >= 2) ? 1 : 0;
        e.arr = 7 - (a % 8);
        e.pd  = pd;
        e.tag = tag;
        sb.push_back(e);
        while (tcnt < e.t + 8) @(posedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        check(out_valid == 1'b0, "R1 valid after reset", out_valid, 0);
        check(deskew_err == 1'b0, "R1 error after reset", deskew_err, 0);
        check(arr_count == 8'd0, "R1 count after reset", arr_count, 0);
        // R3 boundary release, with a repeated lane-0 marker (R10)
        run_case(2, 5, 3, 9, 0, 1'b0, 4'b0000, 1'b1, 7, "R3");
        // R3 offset equal to a mid position
        run_case(4, 1, 6, 2, 3, 1'b0, 4'b0000, 1'b1, -1, "R3");
        // R4 out-of-range offset
        run_case(1, 3, 0, 2, 10, 1'b0, 4'b0000, 1'b1, -1, "R4");
        // R5 force release
        run_case(3, 0, 5, 1, 0, 1'b1, 4'b0000, 1'b1, -1, "R5");
        // R6 latest arrival on the tick
        run_case(7, 2, 4, 7, 0, 1'b0, 4'b0000, 1'b1, -1, "R6");
        // R8 lane 2 masked
        run_case(1, 2, -1, 4, 2, 1'b0, 4'b0100, 1'b1, -1, "R8");
        // R9 user-data marker source
        run_case(2, 6, 1, 3, 0, 1'b0, 4'b0000, 1'b0, -1, "R9");
        // R7 two boundaries crossed
        run_case(0, 1, 2, 18, 0, 1'b0, 4'b0000, 1'b1, -1, "R7");
        // R7 single boundary crossed is legal
        run_case(6, 8, 9, 14, 0, 1'b0, 4'b0000, 1'b1, -1, "R7");
        check(sb.size() == 0, "R2 all releases seen", sb.size(), 0);
        repeat (4) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule